// File: doc/BRIEF.md
# Fully Associative Translation Micro-Cache

This block is a small, fully associative store of address translations that sits between an instruction or data access path and the larger main translation array. Every request presents a virtual page number, an address-space identifier, an access kind and the privilege mode. When a valid entry matches, the physical frame comes back combinationally in the same cycle, together with a permission verdict for the current mode. The same RTL serves both access paths: the data side is built with eight entries and the instruction side with four.

On a miss the block holds the requester in a stall and asks the main array for the translation over a simple request/response pair. A returned entry is written into a free slot, or into the slot named by a round-robin pointer when every slot is occupied. The held request is then retried and hits. A "not present" answer ends the request with a miss fault and allocates nothing.

The main array may later replace its own copy of an entry. That has no effect on this block: every entry stays usable until a single invalidate pulse clears them all. The surrounding logic raises that pulse on an ordinary main-array write or on an explicit flush command. It does not raise it on a write that is meant to leave this cache intact. The pulse is obeyed unconditionally. No other state, including a lookup-error condition left elsewhere by a failed probe, can hold it off.

Top module: `utlb_cache`

## Requirements
- R1: After reset no entry is valid, and with no request present `rsp_done`, `req_stall` and `fill_req_valid` are all low.
- R2: While idle, a request hits when a valid entry has the same page number and either the same identifier or its global flag set. `rsp_done` and the frame appear in that same cycle.
- R3: An entry whose global flag is clear never matches a request that carries a different identifier.
- R4: On a miss, `req_stall` is high in the request cycle. From the next cycle `fill_req_valid` is high, carrying that page and identifier unchanged, until a fill response is accepted.
- R5: A fill response with `fill_rsp_found`=1 is written into an entry at that clock edge and drops `fill_req_valid`. The held request then hits in the following cycle.
- R6: A fill response with `fill_rsp_found`=0 raises `rsp_done` and `rsp_fault_miss` in that same cycle and allocates no entry, so repeating the request misses again.
- R7: Permission bits are [5] kernel read, [4] kernel write, [3] kernel execute, [2] user read, [1] user write, [0] user execute. Access kinds are 0 read, 1 write, 2 execute; kind 3 is never allowed. A hit whose selected bit is clear gives `rsp_fault_perm` with `rsp_done`. The bit is taken from the kernel group when `req_kernel`=1, else from the user group.
- R8: A fill goes to the lowest-numbered invalid entry. When all entries are valid, it goes to a round-robin pointer that starts at 0 after reset and steps by one, wrapping, only on such allocations.
- R9: `inv_pulse` clears every entry at the next edge. A fill response accepted at that same edge is discarded, and the held request retries as a miss.
- R10: A valid entry stays usable indefinitely; only `inv_pulse` or its own replacement removes it, whatever the main array does.
- R11: An `inv_pulse` during an outstanding fill does not cancel the fill. A found response that arrives later is still written and hit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Translation request present; held while stalled |
| req_vpn | input | VPN_W | Virtual page number |
| req_asid | input | ASID_W | Address-space identifier |
| req_acc | input | 2 | Access kind: 0 read, 1 write, 2 execute |
| req_kernel | input | 1 | 1 = kernel mode, 0 = user mode |
| req_stall | output | 1 | Request must be held this cycle |
| rsp_done | output | 1 | Request completes this cycle |
| rsp_pfn | output | PFN_W | Physical frame on a hit, else zero |
| rsp_fault_miss | output | 1 | Main array has no translation |
| rsp_fault_perm | output | 1 | Hit, but the access is not permitted |
| fill_req_valid | output | 1 | Fill request to the main array |
| fill_req_vpn | output | VPN_W | Page number requested |
| fill_req_asid | output | ASID_W | Identifier requested |
| fill_rsp_valid | input | 1 | Fill response present |
| fill_rsp_found | input | 1 | Response carries a translation |
| fill_rsp_pfn | input | PFN_W | Returned frame |
| fill_rsp_perm | input | 6 | Returned permission bits (layout in R7) |
| fill_rsp_global | input | 1 | Returned entry ignores the identifier |
| inv_pulse | input | 1 | Clear all entries |

## Verification
Lookups are tried with repeated addresses, a foreign identifier against a private entry and several identifiers against a global one. Together these separate page matching from identifier matching, and a same-cycle hit from a refill. Each access kind is applied in both modes to a read-only entry and to a kernel-only entry, which shows whether the correct permission group and bit are selected. A sequence of more distinct pages than there are slots exposes the order of free-slot and round-robin replacement through which pages return in one cycle. Dropping a page from the bench's main array shows that the local copy survives. Invalidates are issued while idle, during a stalled fill and on the exact edge of a fill response, which separates the clearing behaviour from the fill bookkeeping.

// File: rtl/utlb_pkg.sv
package utlb_pkg;

   localparam int PERM_W = 6;

   typedef enum logic {
      ST_LOOK = 1'b0,
      ST_FILL = 1'b1
   } utlb_state_e;

   typedef enum logic [1:0] {
      ACC_RD  = 2'd0,
      ACC_WR  = 2'd1,
      ACC_EX  = 2'd2,
      ACC_BAD = 2'd3
   } utlb_acc_e;

   // kernel group in [5:3], user group in [2:0], each ordered read/write/exec
   function automatic logic perm_allows(input logic [PERM_W-1:0] perm,
                                        input logic kernel,
                                        input logic [1:0] acc);
      logic [2:0] grp;
      grp = kernel ? perm[5:3] : perm[2:0];
      case (utlb_acc_e'(acc))
         ACC_RD:  return grp[2];
         ACC_WR:  return grp[1];
         ACC_EX:  return grp[0];
         default: return 1'b0;
      endcase
   endfunction

endpackage

// File: rtl/utlb_entries.sv
module utlb_entries
   import utlb_pkg::*;
#(
   parameter int ENTRIES = 8,
   parameter int VPN_W   = 20,
   parameter int PFN_W   = 20,
   parameter int ASID_W  = 8
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic [VPN_W-1:0]           lk_vpn,
   input  logic [ASID_W-1:0]          lk_asid,
   output logic                       lk_hit,
   output logic [PFN_W-1:0]           lk_pfn,
   output logic [PERM_W-1:0]          lk_perm,
   input  logic                       wr_en,
   input  logic [$clog2(ENTRIES)-1:0] wr_idx,
   input  logic [VPN_W-1:0]           wr_vpn,
   input  logic [ASID_W-1:0]          wr_asid,
   input  logic [PFN_W-1:0]           wr_pfn,
   input  logic [PERM_W-1:0]          wr_perm,
   input  logic                       wr_global,
   input  logic                       clr_all,
   output logic [ENTRIES-1:0]         vld_vec
);

   localparam int IDX_W = $clog2(ENTRIES);

   logic [ENTRIES-1:0] match_vec;
   logic [PFN_W-1:0]   pfn_m  [ENTRIES];
   logic [PERM_W-1:0]  perm_m [ENTRIES];

   for (genvar g = 0; g < ENTRIES; g++) begin : g_ent
      logic              vld;
      logic              glb;
      logic [VPN_W-1:0]  vpn;
      logic [ASID_W-1:0] asid;
      logic [PFN_W-1:0]  pfn;
      logic [PERM_W-1:0] perm;
      logic              sel;

      assign sel = wr_en && (wr_idx == IDX_W'(g));

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)       vld <= 1'b0;
         else if (clr_all) vld <= 1'b0;
         else if (sel)     vld <= 1'b1;
      end

      always_ff @(posedge clk) begin
         if (sel) begin
            glb  <= wr_global;
            vpn  <= wr_vpn;
            asid <= wr_asid;
            pfn  <= wr_pfn;
            perm <= wr_perm;
         end
      end

      assign match_vec[g] = vld && (vpn == lk_vpn) && (glb || (asid == lk_asid));
      assign pfn_m[g]     = match_vec[g] ? pfn  : '0;
      assign perm_m[g]    = match_vec[g] ? perm : '0;
      assign vld_vec[g]   = vld;
   end

   always_comb begin
      lk_pfn  = '0;
      lk_perm = '0;
      for (int i = 0; i < ENTRIES; i++) begin
         lk_pfn  = lk_pfn  | pfn_m[i];
         lk_perm = lk_perm | perm_m[i];
      end
   end

   assign lk_hit = |match_vec;

   // a clear wins over a same-edge write
   p_clear_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
      clr_all |=> (vld_vec == '0));

endmodule

// File: rtl/utlb_victim.sv
module utlb_victim #(
   parameter int ENTRIES = 8
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic [ENTRIES-1:0]         vld_vec,
   input  logic                       alloc,
   output logic [$clog2(ENTRIES)-1:0] vic_idx
);

   localparam int  IDX_W  = $clog2(ENTRIES);
   localparam bit  POW2   = ((ENTRIES & (ENTRIES - 1)) == 0);

   logic             free_any;
   logic [IDX_W-1:0] free_idx;
   logic [IDX_W-1:0] rr_q;
   logic [IDX_W-1:0] rr_nxt;

   always_comb begin
      free_any = 1'b0;
      free_idx = '0;
      for (int i = ENTRIES - 1; i >= 0; i--) begin
         if (!vld_vec[i]) begin
            free_any = 1'b1;
            free_idx = IDX_W'(i);
         end
      end
   end

   if (POW2) begin : g_wrap_natural
      assign rr_nxt = rr_q + 1'b1;
   end else begin : g_wrap_compare
      assign rr_nxt = (rr_q == IDX_W'(ENTRIES - 1)) ? '0 : rr_q + 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                 rr_q <= '0;
      else if (alloc && !free_any) rr_q <= rr_nxt;
   end

   assign vic_idx = free_any ? free_idx : rr_q;

   p_free_first_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (alloc && !(&vld_vec)) |-> !vld_vec[vic_idx]);

   p_rr_in_range_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (32'(rr_q) < ENTRIES));

endmodule

// File: rtl/utlb_cache.sv
module utlb_cache
   import utlb_pkg::*;
#(
   parameter int ENTRIES = 8,
   parameter int VPN_W   = 20,
   parameter int PFN_W   = 20,
   parameter int ASID_W  = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic [VPN_W-1:0]  req_vpn,
   input  logic [ASID_W-1:0] req_asid,
   input  logic [1:0]        req_acc,
   input  logic              req_kernel,
   output logic              req_stall,
   output logic              rsp_done,
   output logic [PFN_W-1:0]  rsp_pfn,
   output logic              rsp_fault_miss,
   output logic              rsp_fault_perm,
   output logic              fill_req_valid,
   output logic [VPN_W-1:0]  fill_req_vpn,
   output logic [ASID_W-1:0] fill_req_asid,
   input  logic              fill_rsp_valid,
   input  logic              fill_rsp_found,
   input  logic [PFN_W-1:0]  fill_rsp_pfn,
   input  logic [5:0]        fill_rsp_perm,
   input  logic              fill_rsp_global,
   input  logic              inv_pulse
);

   localparam int IDX_W = $clog2(ENTRIES);

   if (ENTRIES < 2) begin : g_bad_entries
      $error("utlb_cache: ENTRIES must be at least 2");
   end
   if (VPN_W < 1 || PFN_W < 1 || ASID_W < 1) begin : g_bad_width
      $error("utlb_cache: widths must be positive");
   end

   utlb_state_e       st_q;
   logic [VPN_W-1:0]  cap_vpn_q;
   logic [ASID_W-1:0] cap_asid_q;

   logic              lk_hit;
   logic [PFN_W-1:0]  lk_pfn;
   logic [PERM_W-1:0] lk_perm;
   logic [ENTRIES-1:0] vld_vec;
   logic [IDX_W-1:0]  vic_idx;

   logic look_hit;
   logic fill_take;
   logic fill_alloc;

   assign look_hit   = (st_q == ST_LOOK) && req_valid && lk_hit;
   assign fill_take  = (st_q == ST_FILL) && fill_rsp_valid;
   assign fill_alloc = fill_take && fill_rsp_found && !inv_pulse;

   utlb_entries #(
      .ENTRIES (ENTRIES),
      .VPN_W   (VPN_W),
      .PFN_W   (PFN_W),
      .ASID_W  (ASID_W)
   ) i_entries (
      .clk       (clk),
      .rst_n     (rst_n),
      .lk_vpn    (req_vpn),
      .lk_asid   (req_asid),
      .lk_hit    (lk_hit),
      .lk_pfn    (lk_pfn),
      .lk_perm   (lk_perm),
      .wr_en     (fill_alloc),
      .wr_idx    (vic_idx),
      .wr_vpn    (cap_vpn_q),
      .wr_asid   (cap_asid_q),
      .wr_pfn    (fill_rsp_pfn),
      .wr_perm   (fill_rsp_perm),
      .wr_global (fill_rsp_global),
      .clr_all   (inv_pulse),
      .vld_vec   (vld_vec)
   );

   utlb_victim #(
      .ENTRIES (ENTRIES)
   ) i_victim (
      .clk     (clk),
      .rst_n   (rst_n),
      .vld_vec (vld_vec),
      .alloc   (fill_alloc),
      .vic_idx (vic_idx)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q       <= ST_LOOK;
         cap_vpn_q  <= '0;
         cap_asid_q <= '0;
      end else begin
         case (st_q)
            ST_LOOK: if (req_valid && !lk_hit) begin
               st_q       <= ST_FILL;
               cap_vpn_q  <= req_vpn;
               cap_asid_q <= req_asid;
            end
            ST_FILL: if (fill_rsp_valid) st_q <= ST_LOOK;
            default: st_q <= ST_LOOK;
         endcase
      end
   end

   assign rsp_fault_miss = fill_take && !fill_rsp_found;
   assign rsp_fault_perm = look_hit && !perm_allows(lk_perm, req_kernel, req_acc);
   assign rsp_done       = look_hit || rsp_fault_miss;
   assign rsp_pfn        = look_hit ? lk_pfn : '0;
   assign req_stall      = req_valid && !rsp_done;

   assign fill_req_valid = (st_q == ST_FILL);
   assign fill_req_vpn   = cap_vpn_q;
   assign fill_req_asid  = cap_asid_q;

   p_hit_now_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (!fill_req_valid && req_valid && lk_hit) |-> (rsp_done && !rsp_fault_miss));

   p_fill_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (fill_req_valid && !fill_rsp_valid) |=>
         (fill_req_valid && $stable(fill_req_vpn) && $stable(fill_req_asid)));

   p_found_ends_fill_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (fill_req_valid && fill_rsp_valid && fill_rsp_found) |=> !fill_req_valid);

   p_notfound_noalloc_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (fill_req_valid && fill_rsp_valid && !fill_rsp_found && !inv_pulse) |=>
         (vld_vec == $past(vld_vec)));

   p_fault_excl_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !(rsp_fault_miss && rsp_fault_perm));

   p_inv_clears_r9: assert property (@(posedge clk) disable iff (!rst_n)
      inv_pulse |=> !lk_hit);

endmodule

// File: tb/test_utlb_cache.sv
module test_utlb_cache;

   localparam int CLK_PERIOD = 10;
   localparam int N      = 4;
   localparam int VPN_W  = 20;
   localparam int PFN_W  = 20;
   localparam int ASID_W = 8;
   localparam int MT_MAX = 8;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              req_valid = 1'b0;
   logic [VPN_W-1:0]  req_vpn = '0;
   logic [ASID_W-1:0] req_asid = '0;
   logic [1:0]        req_acc = '0;
   logic              req_kernel = 1'b0;
   logic              req_stall;
   logic              rsp_done;
   logic [PFN_W-1:0]  rsp_pfn;
   logic              rsp_fault_miss;
   logic              rsp_fault_perm;
   logic              fill_req_valid;
   logic [VPN_W-1:0]  fill_req_vpn;
   logic [ASID_W-1:0] fill_req_asid;
   logic              fill_rsp_valid = 1'b0;
   logic              fill_rsp_found = 1'b0;
   logic [PFN_W-1:0]  fill_rsp_pfn = '0;
   logic [5:0]        fill_rsp_perm = '0;
   logic              fill_rsp_global = 1'b0;
   logic              task_inv = 1'b0;
   logic              resp_inv = 1'b0;
   logic              inv_pulse;

   assign inv_pulse = task_inv | resp_inv;

   always #(CLK_PERIOD/2) clk = ~clk;

   utlb_cache #(
      .ENTRIES (N), .VPN_W (VPN_W), .PFN_W (PFN_W), .ASID_W (ASID_W)
   ) i_utlb_cache (
      .clk (clk), .rst_n (rst_n),
      .req_valid (req_valid), .req_vpn (req_vpn), .req_asid (req_asid),
      .req_acc (req_acc), .req_kernel (req_kernel), .req_stall (req_stall),
      .rsp_done (rsp_done), .rsp_pfn (rsp_pfn),
      .rsp_fault_miss (rsp_fault_miss), .rsp_fault_perm (rsp_fault_perm),
      .fill_req_valid (fill_req_valid), .fill_req_vpn (fill_req_vpn),
      .fill_req_asid (fill_req_asid), .fill_rsp_valid (fill_rsp_valid),
      .fill_rsp_found (fill_rsp_found), .fill_rsp_pfn (fill_rsp_pfn),
      .fill_rsp_perm (fill_rsp_perm), .fill_rsp_global (fill_rsp_global),
      .inv_pulse (inv_pulse)
   );

   int n_chk  = 0;
   int n_fail = 0;
   string cur_tag = "R1";

   task automatic check_eq(input string tag, input string what,
                           input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
      end
   endtask

   // ---------------- main translation array (bench side) ----------------
   int mt_n = 0;
   int mt_vpn [MT_MAX];
   int mt_asid[MT_MAX];
   int mt_glob[MT_MAX];
   int mt_perm[MT_MAX];
   int mt_live[MT_MAX];
   bit mt_pause = 1'b0;
   bit inv_next = 1'b0;

   task automatic mt_add(input int v, input int a, input int g, input int p);
      mt_vpn[mt_n] = v; mt_asid[mt_n] = a; mt_glob[mt_n] = g;
      mt_perm[mt_n] = p; mt_live[mt_n] = 1;
      mt_n++;
   endtask

   function automatic int mt_find(input int v, input int a);
      for (int i = 0; i < mt_n; i++)
         if (mt_live[i] != 0 && mt_vpn[i] == v && (mt_glob[i] != 0 || mt_asid[i] == a))
            return i;
      return -1;
   endfunction

   initial begin : responder
      int wcnt;
      int k;
      wcnt = 0;
      forever begin
         @(posedge clk);
         #1;
         fill_rsp_valid = 1'b0;
         resp_inv = 1'b0;
         if (fill_req_valid && !mt_pause) begin
            wcnt++;
            if (wcnt >= 2) begin
               k = mt_find(int'(fill_req_vpn), int'(fill_req_asid));
               fill_rsp_valid  = 1'b1;
               fill_rsp_found  = (k >= 0);
               fill_rsp_pfn    = (k >= 0) ? PFN_W'(32'h80000 | mt_vpn[k]) : '0;
               fill_rsp_perm   = (k >= 0) ? 6'(mt_perm[k]) : '0;
               fill_rsp_global = (k >= 0) ? (mt_glob[k] != 0) : 1'b0;
               resp_inv = inv_next;
               inv_next = 1'b0;
               wcnt = 0;
            end
         end else begin
            wcnt = 0;
         end
      end
   end

   // ---------------- behavioural reference model ----------------
   int mv[N], mvpn[N], masid[N], mglob[N], mpfn[N], mperm[N];
   int mst = 0, mcap_vpn = 0, mcap_asid = 0, mrr = 0;

   function automatic int mfind(input int v, input int a);
      for (int i = 0; i < N; i++)
         if (mv[i] != 0 && mvpn[i] == v && (mglob[i] != 0 || masid[i] == a)) return i;
      return -1;
   endfunction

   function automatic bit allows(input int p, input bit k, input int acc);
      int pos;
      if (acc > 2) return 1'b0;
      pos = (k ? 3 : 0) + (2 - acc);
      return ((p >> pos) & 1) != 0;
   endfunction

   always @(posedge clk) begin
      int hi, vic;
      if (!rst_n) begin
         for (int i = 0; i < N; i++) mv[i] = 0;
         mst = 0; mrr = 0; mcap_vpn = 0; mcap_asid = 0;
      end else begin
         hi = mfind(int'(req_vpn), int'(req_asid));
         if (mst == 0) begin
            if (req_valid && hi < 0) begin
               mst = 1; mcap_vpn = int'(req_vpn); mcap_asid = int'(req_asid);
            end
         end else if (fill_rsp_valid) begin
            mst = 0;
            if (fill_rsp_found && !inv_pulse) begin
               vic = -1;
               for (int i = 0; i < N; i++) if (mv[i] == 0 && vic < 0) vic = i;
               if (vic < 0) begin vic = mrr; mrr = (mrr + 1) % N; end
               mv[vic] = 1; mvpn[vic] = mcap_vpn; masid[vic] = mcap_asid;
               mglob[vic] = int'(fill_rsp_global); mpfn[vic] = int'(fill_rsp_pfn);
               mperm[vic] = int'(fill_rsp_perm);
            end
         end
         if (inv_pulse) for (int i = 0; i < N; i++) mv[i] = 0;
      end
   end

   always @(negedge clk) begin
      int hi;
      bit e_done, e_fm, e_fp, e_stall;
      int e_pfn;
      if (rst_n) begin
         hi = mfind(int'(req_vpn), int'(req_asid));
         e_fm   = (mst == 1) && fill_rsp_valid && !fill_rsp_found;
         e_done = ((mst == 0) && req_valid && hi >= 0) || e_fm;
         e_fp   = (mst == 0) && req_valid && hi >= 0 && !allows(mperm[hi], req_kernel, int'(req_acc));
         e_pfn  = ((mst == 0) && req_valid && hi >= 0) ? mpfn[hi] : 0;
         e_stall = req_valid && !e_done;
         check_eq(cur_tag, "rsp_done", 32'(rsp_done), 32'(e_done));
         check_eq(cur_tag, "rsp_fault_miss", 32'(rsp_fault_miss), 32'(e_fm));
         check_eq(cur_tag, "rsp_fault_perm", 32'(rsp_fault_perm), 32'(e_fp));
         check_eq(cur_tag, "rsp_pfn", 32'(rsp_pfn), 32'(e_pfn));
         check_eq(cur_tag, "req_stall", 32'(req_stall), 32'(e_stall));
         check_eq(cur_tag, "fill_req_valid", 32'(fill_req_valid), 32'(mst));
         if (mst == 1) begin
            check_eq(cur_tag, "fill_req_vpn", 32'(fill_req_vpn), 32'(mcap_vpn));
            check_eq(cur_tag, "fill_req_asid", 32'(fill_req_asid), 32'(mcap_asid));
         end
      end
   end

   // ---------------- stimulus helpers ----------------
   int          l_lat;
   logic [19:0] l_pfn;
   logic        l_fm, l_fp;

   task automatic lookup(input int v, input int a, input int acc, input bit k);
      @(posedge clk); #1;
      req_vpn = VPN_W'(v); req_asid = ASID_W'(a); req_acc = 2'(acc);
      req_kernel = k; req_valid = 1'b1;
      l_lat = 0;
      forever begin
         @(negedge clk);
         l_lat++;
         if (rsp_done) begin
            l_pfn = rsp_pfn; l_fm = rsp_fault_miss; l_fp = rsp_fault_perm;
            break;
         end
         if (l_lat > 200) break;
         @(posedge clk);
      end
      @(posedge clk); #1;
      req_valid = 1'b0;
   endtask

   task automatic expect_lk(input string tag, input int lat, input int pfn,
                            input bit fm, input bit fp);
      check_eq(tag, "latency", 32'(l_lat), 32'(lat));
      check_eq(tag, "pfn", 32'(l_pfn), 32'(pfn));
      check_eq(tag, "miss fault", 32'(l_fm), 32'(fm));
      check_eq(tag, "perm fault", 32'(l_fp), 32'(fp));
   endtask

   task automatic pulse_inv();
      @(posedge clk); #1 task_inv = 1'b1;
      @(posedge clk); #1 task_inv = 1'b0;
   endtask

   // ---------------- watchdog ----------------
   int cyc = 0;
   always @(posedge clk) begin
      cyc++;
      if (cyc > 100000) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

   localparam int A = 'h10, G = 'h20, RO = 'h30, B = 'h40, C = 'h50, D = 'h60;

   initial begin
      mt_add(A, 5, 0, 'h3f);
      mt_add(G, 0, 1, 'h38);
      mt_add(RO, 5, 0, 'h24);
      mt_add(B, 5, 0, 'h3f);
      mt_add(C, 5, 0, 'h3f);
      mt_add(D, 5, 0, 'h3f);

      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      @(negedge clk);
      cur_tag = "R1";
      check_eq("R1", "rsp_done after reset", 32'(rsp_done), 0);
      check_eq("R1", "fill_req_valid after reset", 32'(fill_req_valid), 0);
      check_eq("R1", "req_stall after reset", 32'(req_stall), 0);

      // R4 R5: miss, fill, retry hit; R2 same-cycle hit
      cur_tag = "R4";
      lookup(A, 5, 0, 0);  expect_lk("R4_R5 first access refills", 4, 'h80010, 0, 0);
      cur_tag = "R2";
      lookup(A, 5, 0, 0);  expect_lk("R2 repeat hits now", 1, 'h80010, 0, 0);

      // R3 R6: foreign identifier, not found, no allocation
      cur_tag = "R3";
      lookup(A, 6, 0, 0);  expect_lk("R3_R6 foreign asid misses", 3, 0, 1, 0);
      cur_tag = "R6";
      lookup(A, 6, 0, 0);  expect_lk("R6 not-found left nothing", 3, 0, 1, 0);

      // R2 global, R7 kernel-only permissions
      cur_tag = "R2";
      lookup(G, 9, 0, 1);  expect_lk("R2 global refill", 4, 'h80020, 0, 0);
      lookup(G, 3, 2, 1);  expect_lk("R2 global any asid", 1, 'h80020, 0, 0);
      cur_tag = "R7";
      lookup(G, 3, 0, 0);  expect_lk("R7 user read kernel-only", 1, 'h80020, 0, 1);
      lookup(G, 3, 3, 1);  expect_lk("R7 kind 3 never allowed", 1, 'h80020, 0, 1);

      // R7 read-only page
      lookup(RO, 5, 1, 0); expect_lk("R7 user write read-only", 4, 'h80030, 0, 1);
      lookup(RO, 5, 0, 0); expect_lk("R7 user read read-only", 1, 'h80030, 0, 0);
      lookup(RO, 5, 1, 1); expect_lk("R7 kernel write read-only", 1, 'h80030, 0, 1);
      lookup(RO, 5, 2, 1); expect_lk("R7 kernel exec read-only", 1, 'h80030, 0, 1);

      // R8 replacement: slots 0A 1G 2RO, B fills slot 3, then round-robin from 0
      cur_tag = "R8";
      lookup(B, 5, 0, 0);  expect_lk("R8 last free slot", 4, 'h80040, 0, 0);
      lookup(C, 5, 0, 0);  expect_lk("R8 full, evict slot0", 4, 'h80050, 0, 0);
      lookup(B, 5, 0, 0);  expect_lk("R8 B survives", 1, 'h80040, 0, 0);
      lookup(A, 5, 0, 0);  expect_lk("R8 A was evicted", 4, 'h80010, 0, 0);
      lookup(G, 3, 0, 1);  expect_lk("R8 G evicted by A", 4, 'h80020, 0, 0);
      lookup(RO, 5, 0, 0); expect_lk("R8 RO evicted by G", 4, 'h80030, 0, 0);
      lookup(C, 5, 0, 0);  expect_lk("R8 C still held", 1, 'h80050, 0, 0);
      lookup(B, 5, 0, 0);  expect_lk("R8 pointer wrapped", 4, 'h80040, 0, 0);

      // R10: main array drops B, local copy persists
      cur_tag = "R10";
      mt_live[3] = 0;
      lookup(B, 5, 0, 0);  expect_lk("R10 evicted upstream still hits", 1, 'h80040, 0, 0);
      lookup(A, 5, 0, 0);  expect_lk("R10 other traffic", 1, 'h80010, 0, 0);
      lookup(G, 7, 0, 1);  expect_lk("R10 other traffic G", 1, 'h80020, 0, 0);
      lookup(B, 5, 0, 0);  expect_lk("R10 B still held", 1, 'h80040, 0, 0);

      // R9: invalidate clears all
      cur_tag = "R9";
      pulse_inv();
      lookup(B, 5, 0, 0);  expect_lk("R9 B gone after invalidate", 3, 0, 1, 0);
      lookup(A, 5, 0, 0);  expect_lk("R9 A refetched", 4, 'h80010, 0, 0);

      // R11: invalidate while fill is outstanding
      cur_tag = "R11";
      mt_pause = 1'b1;
      fork
         lookup(G, 1, 0, 1);
         begin
            repeat (3) @(posedge clk);
            pulse_inv();
            repeat (2) @(posedge clk);
            mt_pause = 1'b0;
         end
      join
      check_eq("R11", "pfn after paused fill", 32'(l_pfn), 'h80020);
      lookup(G, 1, 0, 1);  expect_lk("R11 late fill was kept", 1, 'h80020, 0, 0);
      lookup(A, 5, 0, 0);  expect_lk("R11 A cleared by invalidate", 4, 'h80010, 0, 0);

      // R9: invalidate on the same edge as a fill response
      cur_tag = "R9";
      inv_next = 1'b1;
      lookup(D, 5, 0, 0);  expect_lk("R9 coincident fill dropped", 7, 'h80060, 0, 0);
      lookup(G, 1, 0, 1);  expect_lk("R9 coincident clear", 4, 'h80020, 0, 0);

      repeat (3) @(posedge clk);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

endmodule